// File: doc/BRIEF.md
# SMBus host controller register sequencer

This block is the register side of a host SMBus controller. A processor reaches it through a byte-wide port made of a write strobe, an offset, write data and a combinational read-back byte. Software loads a slave address with its direction bit, a command byte and up to two data bytes. It then writes the control register with a transaction type and the start bit set. The block hands the transaction to a bit-level bus engine through a request/response interface. The engine does the wire timing.

When the engine finishes, the block drops its busy flag and records the outcome in sticky status flags. Software clears a flag by writing 1 to it, so writing back the status value it just read clears every flag it saw. A read transaction also stores the returned bytes in the data registers. A new transaction cannot start while busy or any outcome flag is still set. A packet-error-check enable in an auxiliary control register travels to the engine with each transaction except the quick one.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0x00, `eng_req` is low and `eng_pec` is low.
- R2: The register offsets are: status 0, control 2, command 3, slave address 4, data0 5, data1 6, block data 7, PEC byte 8, auxiliary status 12, auxiliary control 13. Command, slave address, data0, data1, block data and PEC byte read back the last byte written to them. Auxiliary status and every unmapped offset read 0x00.
- R3: Writing control with bit 6 (start) set and bits 5:4 clear starts a transaction, provided the start is not refused (R7). Bits 3:2 give the type: 0x00 quick, 0x04 byte, 0x08 byte-data, 0x0C word. In the next cycle status bit 0 (busy) is 1 and `eng_req` is 1. At the same time `eng_op` equals control bits 3:2, `eng_addr` equals the slave address register (7-bit address in bits 7:1, bit 0 = 1 for read), `eng_cmd` equals the command register, and `eng_wdata` equals {data1, data0}. The start bit always reads back 0; the other control bits read back as written.
- R4: `eng_req` stays high until the cycle in which `eng_done` is sampled high. In the cycle after that sample, busy is 0 and exactly one outcome flag has been set. The flag depends on `eng_resp`: 0 success sets bit 1 (complete), 1 no-acknowledge sets bit 2 (device error), 2 arbitration loss sets bit 3 (collision), and 3 failure sets bit 4 (failed).
- R5: A successful read of type byte or byte-data loads `eng_rdata[7:0]` into data0 and leaves data1 unchanged. A successful word read loads `eng_rdata[7:0]` into data0 and `eng_rdata[15:8]` into data1. Writes, quick transactions and failed transactions leave data0 and data1 unchanged.
- R6: A status write clears each of bits 4:1 that is written with 1 and leaves bits written with 0 unchanged. Busy (bit 0) is not affected by status writes. Bits 7:5 read 0.
- R7: A start write is ignored while any of status bits 4:0 is set. `eng_req` does not rise, and status, data0 and data1 are unchanged.
- R8: While busy, writes to control, command, slave address, data0 and data1 are ignored.
- R9: A start write with control bits 5:4 not both 0 (for example 0x54 or 0x74) issues no engine request. It sets status bit 4 (failed) in the cycle after the write.
- R10: Auxiliary control bit 0 is the PEC enable. It resets to 0 and reads back as written in bit 0, with the other bits reading 0. While a transaction runs, `eng_pec` equals this bit, except that it is 0 for a quick transaction.
- R11: If an outcome flag is set in the same cycle as a status write that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the register at `reg_addr` |
| eng_req | output | 1 | Transaction request to the bus engine, held until done |
| eng_op | output | 2 | Transaction type: 0 quick, 1 byte, 2 byte-data, 3 word |
| eng_addr | output | 8 | Slave address in bits 7:1, read flag in bit 0 |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Write data, high byte data1, low byte data0 |
| eng_pec | output | 1 | Packet error check requested |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_resp | input | 2 | Outcome: 0 ok, 1 no-ack, 2 arbitration lost, 3 failed |
| eng_rdata | input | 16 | Bytes returned by a read |

## Verification
The engine's completion and a software write to the status register can fall in the same cycle. In that cycle the flag being set and the write-1 clear hit the same bit. The bench's engine model answers a fixed number of cycles after the request. This lets the bench place a status write of 0xFF exactly on the edge that samples `eng_done`, and it confirms that alignment at the port first. The bench judges the result by reading status afterwards: the new complete flag must still be set and busy must be clear.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   localparam int unsigned OFS_STS  = 0;
   localparam int unsigned OFS_CTL  = 2;
   localparam int unsigned OFS_CMD  = 3;
   localparam int unsigned OFS_ADR  = 4;
   localparam int unsigned OFS_D0   = 5;
   localparam int unsigned OFS_D1   = 6;
   localparam int unsigned OFS_BLK  = 7;
   localparam int unsigned OFS_PECB = 8;
   localparam int unsigned OFS_AUXS = 12;
   localparam int unsigned OFS_AUXC = 13;

   typedef enum logic [1:0] {
      RESP_OK   = 2'd0,
      RESP_NACK = 2'd1,
      RESP_ARB  = 2'd2,
      RESP_FAIL = 2'd3
   } resp_e;

   typedef enum logic [1:0] {
      OP_QUICK = 2'd0,
      OP_BYTE  = 2'd1,
      OP_BDATA = 2'd2,
      OP_WORD  = 2'd3
   } op_e;
endpackage

// File: rtl/smbh_launch.sv
module smbh_launch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [2:0] ctl_bits,
   input  logic       flags_any,
   input  logic       eng_done,
   output logic       launch,
   output logic       bad_type,
   output logic       fin,
   output logic       eng_req
);
   logic go;

   assign go       = ctl_wr && ctl_bits[2] && !flags_any;
   assign launch   = go && (ctl_bits[1:0] == 2'b00);
   assign bad_type = go && (ctl_bits[1:0] != 2'b00);
   assign fin      = eng_req && eng_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eng_req <= 1'b0;
      else if (launch)  eng_req <= 1'b1;
      else if (fin)     eng_req <= 1'b0;
   end

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && !eng_done |=> eng_req);

   // R7
   refuse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_bits[2] && flags_any |=> !$rose(eng_req));

   // R9
   bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_type |=> !$rose(eng_req));
endmodule

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sts_wr,
   input  logic [3:0] clr_bits,
   input  logic       launch,
   input  logic       bad_type,
   input  logic       fin,
   input  logic [1:0] eng_resp,
   output logic       busy,
   output logic [3:0] flags
);
   logic [3:0] set_vec;
   logic [3:0] clr_vec;

   always_comb begin
      set_vec = 4'b0000;
      if (fin) begin
         case (resp_e'(eng_resp))
            RESP_OK:   set_vec[0] = 1'b1;
            RESP_NACK: set_vec[1] = 1'b1;
            RESP_ARB:  set_vec[2] = 1'b1;
            default:   set_vec[3] = 1'b1;
         endcase
      end
      if (bad_type) set_vec[3] = 1'b1;
      clr_vec = sts_wr ? clr_bits : 4'b0000;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         flags <= 4'b0000;
      end else begin
         if (launch)   busy <= 1'b1;
         else if (fin) busy <= 1'b0;
         flags <= (flags & ~clr_vec) | set_vec;
      end
   end

   // R4
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && fin |=> !busy);

   // R4
   one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && fin |=> $countones(flags & ~$past(flags)) == 1);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin && sts_wr |=> flags != 4'b0000);
endmodule

// File: rtl/smbh_regs.sv
module smbh_regs
   import smbh_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned OFS_W   = 4,
   parameter bit          HAS_PEC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [OFS_W-1:0]  reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic [3:0]        flags,
   input  logic              fin,
   input  logic [1:0]        eng_resp,
   input  logic [2*BYTE_W-1:0] eng_rdata,
   output logic [1:0]        eng_op,
   output logic [BYTE_W-1:0] eng_addr,
   output logic [BYTE_W-1:0] eng_cmd,
   output logic [2*BYTE_W-1:0] eng_wdata,
   output logic              eng_pec
);
   localparam logic [BYTE_W-1:0] START_MASK = ~(BYTE_W'(1) << 6);

   logic [BYTE_W-1:0] ctl_q, cmd_q, adr_q, d0_q, d1_q, blk_q, pecb_q;
   logic              auxc_q;
   logic              capture;
   logic [BYTE_W-1:0] sts_byte;

   function automatic logic hit(input logic [OFS_W-1:0] a, input int unsigned ofs);
      return a == OFS_W'(ofs);
   endfunction

   assign capture  = fin && (resp_e'(eng_resp) == RESP_OK) && adr_q[0] &&
                     (op_e'(ctl_q[3:2]) != OP_QUICK);
   assign sts_byte = {{(BYTE_W-5){1'b0}}, flags, busy};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmd_q  <= '0;
         adr_q  <= '0;
         d0_q   <= '0;
         d1_q   <= '0;
         blk_q  <= '0;
         pecb_q <= '0;
      end else begin
         if (reg_we && !busy) begin
            if (hit(reg_addr, OFS_CTL)) ctl_q <= reg_wdata & START_MASK;
            if (hit(reg_addr, OFS_CMD)) cmd_q <= reg_wdata;
            if (hit(reg_addr, OFS_ADR)) adr_q <= reg_wdata;
            if (hit(reg_addr, OFS_D0))  d0_q  <= reg_wdata;
            if (hit(reg_addr, OFS_D1))  d1_q  <= reg_wdata;
         end
         if (reg_we && hit(reg_addr, OFS_BLK))  blk_q  <= reg_wdata;
         if (reg_we && hit(reg_addr, OFS_PECB)) pecb_q <= reg_wdata;
         if (capture) begin
            d0_q <= eng_rdata[BYTE_W-1:0];
            if (op_e'(ctl_q[3:2]) == OP_WORD) d1_q <= eng_rdata[2*BYTE_W-1:BYTE_W];
         end
      end
   end

   generate
      if (HAS_PEC) begin : g_pec
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) auxc_q <= 1'b0;
            else if (reg_we && hit(reg_addr, OFS_AUXC)) auxc_q <= reg_wdata[0];
         end
         assign eng_pec = auxc_q && (op_e'(ctl_q[3:2]) != OP_QUICK);
      end else begin : g_nopec
         assign auxc_q  = 1'b0;
         assign eng_pec = 1'b0;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if      (hit(reg_addr, OFS_STS))  reg_rdata = sts_byte;
      else if (hit(reg_addr, OFS_CTL))  reg_rdata = ctl_q;
      else if (hit(reg_addr, OFS_CMD))  reg_rdata = cmd_q;
      else if (hit(reg_addr, OFS_ADR))  reg_rdata = adr_q;
      else if (hit(reg_addr, OFS_D0))   reg_rdata = d0_q;
      else if (hit(reg_addr, OFS_D1))   reg_rdata = d1_q;
      else if (hit(reg_addr, OFS_BLK))  reg_rdata = blk_q;
      else if (hit(reg_addr, OFS_PECB)) reg_rdata = pecb_q;
      else if (hit(reg_addr, OFS_AUXC)) reg_rdata = {{(BYTE_W-1){1'b0}}, auxc_q};
   end

   assign eng_op    = ctl_q[3:2];
   assign eng_addr  = adr_q;
   assign eng_cmd   = cmd_q;
   assign eng_wdata = {d1_q, d0_q};

   // R8
   launch_regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !fin |=> $stable({eng_op, eng_addr, eng_cmd, eng_wdata}));

   // R5
   data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin && !capture |=> $stable(eng_wdata));

   // R10
   quick_no_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (op_e'(eng_op) == OP_QUICK) |-> !eng_pec);
endmodule

// File: rtl/smbh_host.sv
module smbh_host
   import smbh_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned OFS_W   = 4,
   parameter bit          HAS_PEC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [OFS_W-1:0]    reg_addr,
   input  logic [BYTE_W-1:0]   reg_wdata,
   output logic [BYTE_W-1:0]   reg_rdata,
   output logic                eng_req,
   output logic [1:0]          eng_op,
   output logic [BYTE_W-1:0]   eng_addr,
   output logic [BYTE_W-1:0]   eng_cmd,
   output logic [2*BYTE_W-1:0] eng_wdata,
   output logic                eng_pec,
   input  logic                eng_done,
   input  logic [1:0]          eng_resp,
   input  logic [2*BYTE_W-1:0] eng_rdata
);
   initial begin
      byte_width_chk: assert (BYTE_W == 8);
      offset_width_chk: assert (OFS_W >= 4);
   end

   logic       busy, launch, bad_type, fin;
   logic [3:0] flags;
   logic       ctl_wr, sts_wr;

   assign ctl_wr = reg_we && (reg_addr == OFS_W'(OFS_CTL));
   assign sts_wr = reg_we && (reg_addr == OFS_W'(OFS_STS));

   smbh_launch u_launch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_bits  (reg_wdata[6:4]),
      .flags_any (busy || (flags != 4'b0000)),
      .eng_done  (eng_done),
      .launch    (launch),
      .bad_type  (bad_type),
      .fin       (fin),
      .eng_req   (eng_req)
   );

   smbh_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_wr   (sts_wr),
      .clr_bits (reg_wdata[4:1]),
      .launch   (launch),
      .bad_type (bad_type),
      .fin      (fin),
      .eng_resp (eng_resp),
      .busy     (busy),
      .flags    (flags)
   );

   smbh_regs #(
      .BYTE_W  (BYTE_W),
      .OFS_W   (OFS_W),
      .HAS_PEC (HAS_PEC)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .flags     (flags),
      .fin       (fin),
      .eng_resp  (eng_resp),
      .eng_rdata (eng_rdata),
      .eng_op    (eng_op),
      .eng_addr  (eng_addr),
      .eng_cmd   (eng_cmd),
      .eng_wdata (eng_wdata),
      .eng_pec   (eng_pec)
   );

   // R3
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |-> busy);
endmodule

// File: tb/sim_smbh_host.sv
module sim_smbh_host;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        eng_req, eng_pec;
   logic [1:0]  eng_op;
   logic [7:0]  eng_addr, eng_cmd;
   logic [15:0] eng_wdata;
   logic        eng_done;
   logic [1:0]  eng_resp;
   logic [15:0] eng_rdata;

   always #10 clk = ~clk;

   smbh_host u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
      .eng_op(eng_op), .eng_addr(eng_addr), .eng_cmd(eng_cmd),
      .eng_wdata(eng_wdata), .eng_pec(eng_pec), .eng_done(eng_done),
      .eng_resp(eng_resp), .eng_rdata(eng_rdata)
   );

   // bus engine model: answers 4 edges after seeing the request
   localparam int LAT = 4;
   int stub_cnt;
   function automatic logic [1:0] resp_for(input logic [6:0] a7);
      case (a7)
         7'h50:   return 2'd0;
         7'h11:   return 2'd2;
         7'h33:   return 2'd3;
         default: return 2'd1;
      endcase
   endfunction
   assign eng_resp  = resp_for(eng_addr[7:1]);
   assign eng_rdata = {eng_cmd + 8'd1, eng_cmd ^ eng_addr};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_done <= 1'b0;
         stub_cnt <= 0;
      end else if (eng_req && !eng_done) begin
         if (stub_cnt == LAT - 1) eng_done <= 1'b1;
         stub_cnt <= stub_cnt + 1;
      end else begin
         eng_done <= 1'b0;
         stub_cnt <= 0;
      end
   end

   // scoreboard
   logic [15:0] exp_q[$];
   logic [15:0] act_q[$];
   string       tag_q[$];
   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 1'b0;

   initial begin
      forever begin
         wait (act_q.size() != 0);
         begin
            logic [15:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (a !== e) begin
               n_errors++;
               $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
         end
      end
   end

   task automatic push(input string t, input logic [15:0] act, input logic [15:0] expv);
      exp_q.push_back(expv);
      tag_q.push_back(t);
      act_q.push_back(act);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic check_reg(input string t, input logic [3:0] a, input logic [7:0] expv);
      logic [7:0] v;
      rd(a, v);
      push(t, {8'h00, v}, {8'h00, expv});
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int i = 0; i < 40; i++) begin
         rd(4'd0, s);
         if (!s[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic setup(input logic [7:0] adr, input logic [7:0] cmd,
                        input logic [7:0] d0, input logic [7:0] d1);
      wr(4'd4, adr); wr(4'd3, cmd); wr(4'd5, d0); wr(4'd6, d1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] c;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_reg("R1 status", 4'd0, 8'h00);
      check_reg("R1 control", 4'd2, 8'h00);
      check_reg("R1 data0", 4'd5, 8'h00);
      check_reg("R1 auxctl", 4'd13, 8'h00);
      push("R1 eng_req", {15'd0, eng_req}, 16'd0);
      push("R1 eng_pec", {15'd0, eng_pec}, 16'd0);

      // R2 register map
      setup(8'hA0, 8'h3C, 8'h11, 8'h22);
      wr(4'd7, 8'h77); wr(4'd8, 8'h99); wr(4'd12, 8'hEE); wr(4'd1, 8'hDD);
      check_reg("R2 cmd", 4'd3, 8'h3C);
      check_reg("R2 addr", 4'd4, 8'hA0);
      check_reg("R2 data0", 4'd5, 8'h11);
      check_reg("R2 data1", 4'd6, 8'h22);
      check_reg("R2 block", 4'd7, 8'h77);
      check_reg("R2 pecbyte", 4'd8, 8'h99);
      check_reg("R2 auxsts", 4'd12, 8'h00);
      check_reg("R2 unmapped", 4'd1, 8'h00);

      // R3 byte-data write launch
      wr(4'd2, 8'h48);
      push("R3 eng_req", {15'd0, eng_req}, 16'd1);
      push("R3 eng_op", {14'd0, eng_op}, 16'd2);
      push("R3 eng_addr", {8'd0, eng_addr}, 16'h00A0);
      push("R3 eng_cmd", {8'd0, eng_cmd}, 16'h003C);
      push("R3 eng_wdata", eng_wdata, 16'h2211);
      check_reg("R3 busy", 4'd0, 8'h01);
      check_reg("R3 ctl readback", 4'd2, 8'h08);
      // R8 write during busy ignored; R6 busy not writable
      wr(4'd5, 8'h55);
      wr(4'd0, 8'h01);
      check_reg("R6 busy kept", 4'd0, 8'h01);
      wait_idle();
      check_reg("R4 complete", 4'd0, 8'h02);
      push("R4 req dropped", {15'd0, eng_req}, 16'd0);
      check_reg("R8 data0 kept", 4'd5, 8'h11);
      check_reg("R5 write keeps data1", 4'd6, 8'h22);
      wr(4'd0, 8'h00);
      check_reg("R6 zero keeps", 4'd0, 8'h02);
      wr(4'd0, 8'h02);
      check_reg("R6 clear", 4'd0, 8'h00);

      // R5 byte-data read
      setup(8'hA1, 8'h3C, 8'h00, 8'h66);
      wr(4'd2, 8'h48);
      wait_idle();
      check_reg("R5 bdata read status", 4'd0, 8'h02);
      check_reg("R5 bdata d0", 4'd5, 8'h3C ^ 8'hA1);
      check_reg("R5 bdata d1 kept", 4'd6, 8'h66);
      wr(4'd0, 8'h02);

      // R5 word read
      setup(8'hA1, 8'h80, 8'h00, 8'h00);
      wr(4'd2, 8'h4C);
      wait_idle();
      check_reg("R5 word d0", 4'd5, 8'h80 ^ 8'hA1);
      check_reg("R5 word d1", 4'd6, 8'h81);
      wr(4'd0, 8'h02);

      // R5 byte read (type 0x04)
      setup(8'hA1, 8'h0F, 8'h00, 8'h44);
      wr(4'd2, 8'h44);
      wait_idle();
      check_reg("R5 byte d0", 4'd5, 8'h0F ^ 8'hA1);
      check_reg("R5 byte d1 kept", 4'd6, 8'h44);
      wr(4'd0, 8'h02);

      // R4 no-acknowledge, R5 error keeps data
      setup(8'h55, 8'h10, 8'hAB, 8'hCD);
      wr(4'd2, 8'h4C);
      wait_idle();
      check_reg("R4 nack", 4'd0, 8'h04);
      check_reg("R5 err d0", 4'd5, 8'hAB);
      check_reg("R5 err d1", 4'd6, 8'hCD);

      // R7 start refused with flag set
      setup(8'hA1, 8'h01, 8'h12, 8'h34);
      wr(4'd2, 8'h4C);
      push("R7 no req", {15'd0, eng_req}, 16'd0);
      repeat (6) @(negedge clk);
      push("R7 still no req", {15'd0, eng_req}, 16'd0);
      check_reg("R7 status kept", 4'd0, 8'h04);
      check_reg("R7 d0 kept", 4'd5, 8'h12);
      wr(4'd0, 8'h04);
      check_reg("R6 clear nack", 4'd0, 8'h00);

      // R4 collision and failure
      wr(4'd4, 8'h22);
      wr(4'd2, 8'h44);
      wait_idle();
      check_reg("R4 collision", 4'd0, 8'h08);
      wr(4'd0, 8'h08);
      wr(4'd4, 8'h66);
      wr(4'd2, 8'h44);
      wait_idle();
      check_reg("R4 failed", 4'd0, 8'h10);
      wr(4'd0, 8'h1E);
      check_reg("R6 clear all", 4'd0, 8'h00);

      // R9 unsupported type
      wr(4'd2, 8'h54);
      push("R9 no req", {15'd0, eng_req}, 16'd0);
      check_reg("R9 failed", 4'd0, 8'h10);
      wr(4'd0, 8'h10);
      wr(4'd2, 8'h74);
      check_reg("R9 failed 0x74", 4'd0, 8'h10);
      wr(4'd0, 8'h10);

      // R10 PEC enable
      wr(4'd13, 8'hFF);
      check_reg("R10 auxctl", 4'd13, 8'h01);
      wr(4'd4, 8'hA0);
      wr(4'd2, 8'h48);
      push("R10 pec bdata", {15'd0, eng_pec}, 16'd1);
      wait_idle();
      wr(4'd0, 8'h02);
      wr(4'd2, 8'h40);
      push("R10 quick req", {15'd0, eng_req}, 16'd1);
      push("R10 pec quick", {15'd0, eng_pec}, 16'd0);
      wait_idle();
      wr(4'd0, 8'h02);
      wr(4'd13, 8'h00);
      check_reg("R10 auxctl off", 4'd13, 8'h00);

      // R11 done and status clear in the same cycle
      wr(4'd2, 8'h48);
      repeat (LAT) @(negedge clk);
      push("R11 align", {15'd0, eng_done}, 16'd1);
      wr(4'd0, 8'hFF);
      check_reg("R11 set wins", 4'd0, 8'h02);
      rd(4'd0, c);
      wr(4'd0, c);
      check_reg("R6 write back clears", 4'd0, 8'h00);

      wait (act_q.size() == 0);
      #1;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule